// File: doc/BRIEF.md
# Recirculating Per-Voice Sample Buffer

This block keeps one output sample for each of sixteen voices that a time-multiplexed synthesis engine produces one after another. The samples live in a sixteen-stage ring of registers that rotates by one stage on every clock. Each entry holds a 12-bit data word together with a 4-bit scale code that drives four scale-factor lines. A stage normally takes back the value leaving the end of the ring, so the contents circulate unchanged. When the engine has a fresh sample, a load strobe makes the head of the ring take the new entry, and the old one is discarded.

The ring rotates at the engine clock, but a converter downstream needs each voice presented on its own and spread evenly across the frame. Two latches sit between the ring and the output pins and take turns. One latch drives the pins. The other waits for the wanted voice to reach the end of the ring and grabs it on a capture strobe. A swap strobe then exchanges their roles. The timing of the capture and swap strobes decides which voice appears on the pins and when.

Top module: `voice_ring_buffer`

## Requirements
- R1: After reset, every ring stage and both latches hold zero, latch A drives the pins, and the pins read data 0 and scale 0.
- R2: The ring advances one stage per clock. An entry loaded at clock edge k is at the ring tail during the cycle after edge k+15, so a capture at edge k+16 picks it up.
- R3: While the load strobe is low, the entry leaving the tail re-enters the head, so an entry comes back to the tail every 16 clocks with no change.
- R4: While the load strobe is high at an edge, the head takes the new data and scale in place of the recirculated entry, and that recirculated entry is lost.
- R5: The data word and the scale code of an entry travel together. The pins show data on `outData[11:0]` and the matching scale code on `outScale[3:0]`, taken from the same entry.
- R6: A capture strobe writes the current tail entry into the latch that is not driving the pins. It never writes the driving latch, so a capture without a swap leaves the pins unchanged.
- R7: A swap strobe exchanges the roles of the latches. From the next cycle the pins show the latch that was capturing before.
- R8: With no swap strobe at an edge, the pins hold their value across that edge, whatever the ring and the load and capture strobes do.
- R9: When capture and swap are high at the same edge, the tail entry is captured into the idle latch, and that same entry is on the pins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine clock; the ring rotates on every rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Head of the ring takes the new sample instead of the recirculated one |
| loadData | input | 12 | Data word of the new sample |
| loadScale | input | 4 | Scale code of the new sample |
| captureEn | input | 1 | Idle latch takes the entry at the ring tail |
| swapEn | input | 1 | Latches exchange their driving and capturing roles |
| outData | output | 12 | Data word from the driving latch |
| outScale | output | 4 | Scale code from the driving latch |

## Verification
A directed pass loads sixteen distinct voices in a row, then lets them circulate without loads. It uses capture-and-swap pairs at chosen offsets to show that each voice reaches the tail exactly 16 clocks after its load and again 16 clocks later. This separates an off-by-one ring length from correct recirculation. A directed overwrite puts a new sample into a slot that already holds a voice, which tells a load that replaces apart from one that is lost or merged. Constrained random traffic then mixes loads, lone captures, lone swaps and simultaneous capture-swap pairs at set rates. Every pin value is compared with a rotating sixteen-entry array model, which exposes a capture into the wrong latch or a swap that does not happen.

// File: rtl/voice_ring_pkg.sv
package voice_ring_pkg;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic takeNew;   // head stage takes the fresh sample
    logic capA;      // latch A captures the ring tail
    logic capB;      // latch B captures the ring tail
    logic driveB;    // latch B drives the pins (else latch A)
  } ring_strobe_t;

endpackage

// File: rtl/voice_ring_ctrl.sv
module voice_ring_ctrl
  import voice_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadEn,
  input  logic         captureEn,
  input  logic         swapEn,
  output ring_strobe_t strb,
  output logic         driveSelB
);

  logic selB;

  // Role register: 0 means latch A drives the pins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selB <= 1'b0;
    end else if (swapEn) begin
      selB <= ~selB;
    end
  end

  always_comb begin
    strb.takeNew = loadEn;
    strb.capA    = captureEn &  selB;
    strb.capB    = captureEn & ~selB;
    strb.driveB  = selB;
  end

  assign driveSelB = selB;

endmodule

// File: rtl/voice_ring_datapath.sv
module voice_ring_datapath
  import voice_ring_pkg::*;
#(
  parameter int NUM_VOICES = 16,
  parameter int DATA_W     = 12,
  parameter int SCALE_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ring_strobe_t       strb,
  input  logic [DATA_W-1:0]  newData,
  input  logic [SCALE_W-1:0] newScale,
  output logic [DATA_W-1:0]  pinData,
  output logic [SCALE_W-1:0] pinScale,
  output logic [DATA_W+SCALE_W-1:0] headEntry,
  output logic [DATA_W+SCALE_W-1:0] tailEntry
);

  localparam int ENTRY_W = DATA_W + SCALE_W;
  localparam int LAST    = NUM_VOICES - 1;

  logic [ENTRY_W-1:0] stageQ [NUM_VOICES];
  logic [ENTRY_W-1:0] latA;
  logic [ENTRY_W-1:0] latB;
  logic [ENTRY_W-1:0] pinEntry;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_VOICES; gi++) begin : g_stage
      logic [ENTRY_W-1:0] regQ;
      if (gi == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            regQ <= '0;
          end else if (strb.takeNew) begin
            regQ <= {newData, newScale};
          end else begin
            regQ <= stageQ[LAST];
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            regQ <= '0;
          end else begin
            regQ <= stageQ[gi-1];
          end
        end
      end
      assign stageQ[gi] = regQ;
    end
  endgenerate

  // Ping-pong output latches.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latA <= '0;
      latB <= '0;
    end else begin
      if (strb.capA) latA <= stageQ[LAST];
      if (strb.capB) latB <= stageQ[LAST];
    end
  end

  assign pinEntry  = strb.driveB ? latB : latA;
  assign pinData   = pinEntry[ENTRY_W-1:SCALE_W];
  assign pinScale  = pinEntry[SCALE_W-1:0];
  assign headEntry = stageQ[0];
  assign tailEntry = stageQ[LAST];

endmodule

// File: rtl/voice_ring_buffer.sv
module voice_ring_buffer
  import voice_ring_pkg::*;
#(
  parameter int NUM_VOICES = 16,
  parameter int DATA_W     = 12,
  parameter int SCALE_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [DATA_W-1:0]  loadData,
  input  logic [SCALE_W-1:0] loadScale,
  input  logic               captureEn,
  input  logic               swapEn,
  output logic [DATA_W-1:0]  outData,
  output logic [SCALE_W-1:0] outScale
);

  localparam int ENTRY_W = DATA_W + SCALE_W;

  ring_strobe_t       strb;
  logic               driveSelB;
  logic [ENTRY_W-1:0] headEntry;
  logic [ENTRY_W-1:0] tailEntry;

  voice_ring_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .captureEn (captureEn),
    .swapEn    (swapEn),
    .strb      (strb),
    .driveSelB (driveSelB)
  );

  voice_ring_datapath #(
    .NUM_VOICES (NUM_VOICES),
    .DATA_W     (DATA_W),
    .SCALE_W    (SCALE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .newData   (loadData),
    .newScale  (loadScale),
    .pinData   (outData),
    .pinScale  (outScale),
    .headEntry (headEntry),
    .tailEntry (tailEntry)
  );

endmodule

// File: rtl/voice_ring_checker.sv
module voice_ring_checker #(
  parameter int DATA_W  = 12,
  parameter int SCALE_W = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      loadEn,
  input logic [DATA_W-1:0]         loadData,
  input logic [SCALE_W-1:0]        loadScale,
  input logic                      captureEn,
  input logic                      swapEn,
  input logic                      driveSelB,
  input logic [DATA_W+SCALE_W-1:0] headEntry,
  input logic [DATA_W+SCALE_W-1:0] tailEntry,
  input logic [DATA_W-1:0]         outData,
  input logic [SCALE_W-1:0]        outScale
);

  // R3: without a load the tail value re-enters the head
  a_r3_recirculate: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> headEntry == $past(tailEntry));

  // R4: a load places the new sample at the head
  a_r4_load_head: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> headEntry == $past({loadData, loadScale}));

  // R7: a swap flips the driving latch
  a_r7_swap_flips: assert property (@(posedge clk) disable iff (!rstN)
    swapEn |=> driveSelB != $past(driveSelB));

  // R8: pins hold steady without a swap
  a_r8_pins_hold: assert property (@(posedge clk) disable iff (!rstN)
    !swapEn |=> $stable(outData) && $stable(outScale));

  // R9: capture with swap puts the tail entry straight on the pins
  a_r9_capture_swap: assert property (@(posedge clk) disable iff (!rstN)
    (captureEn && swapEn) |=> {outData, outScale} == $past(tailEntry));

endmodule

bind voice_ring_buffer voice_ring_checker #(
  .DATA_W  (DATA_W),
  .SCALE_W (SCALE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadEn    (loadEn),
  .loadData  (loadData),
  .loadScale (loadScale),
  .captureEn (captureEn),
  .swapEn    (swapEn),
  .driveSelB (driveSelB),
  .headEntry (headEntry),
  .tailEntry (tailEntry),
  .outData   (outData),
  .outScale  (outScale)
);

// File: tb/sim_voice_ring_buffer.sv
`timescale 1ns/1ps
module sim_voice_ring_buffer;

  localparam int NV = 16;
  localparam int DW = 12;
  localparam int SW = 4;
  localparam int EW = DW + SW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadEn = 1'b0;
  logic [DW-1:0] loadData = '0;
  logic [SW-1:0] loadScale = '0;
  logic          captureEn = 1'b0;
  logic          swapEn = 1'b0;
  logic [DW-1:0] outData;
  logic [SW-1:0] outScale;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Reference model: rotating circular array plus two latches.
  logic [EW-1:0] mRing [NV];
  logic [EW-1:0] mLatA;
  logic [EW-1:0] mLatB;
  bit            mSelB;
  string         curTag = "";

  always #10 clk = ~clk;

  voice_ring_buffer #(.NUM_VOICES(NV), .DATA_W(DW), .SCALE_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadData(loadData),
    .loadScale(loadScale), .captureEn(captureEn), .swapEn(swapEn),
    .outData(outData), .outScale(outScale)
  );

  function automatic logic [EW-1:0] modelPins();
    return mSelB ? mLatB : mLatA;
  endfunction

  task automatic checkPins(input string tag, input logic [EW-1:0] expv);
    total++;
    if ({outData, outScale} !== expv) begin
      bad++;
      $display("FAIL %s: pins data=%h scale=%h expected data=%h scale=%h",
               tag, outData, outScale, expv[EW-1:SW], expv[SW-1:0]);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < NV; i++) mRing[i] = '0;
    mLatA = '0;
    mLatB = '0;
    mSelB = 1'b0;
  endfunction

  function automatic void modelEdge(input bit ld, input logic [EW-1:0] nv,
                                    input bit cap, input bit sw);
    logic [EW-1:0] tail;
    tail = mRing[NV-1];
    if (cap) begin
      if (mSelB) mLatA = tail;
      else       mLatB = tail;
    end
    if (sw) mSelB = ~mSelB;
    for (int i = NV-1; i > 0; i--) mRing[i] = mRing[i-1];
    mRing[0] = ld ? nv : tail;
  endfunction

  // One clock: drive at negedge, model at posedge, check at next negedge.
  task automatic step(input bit ld, input logic [DW-1:0] d, input logic [SW-1:0] s,
                      input bit cap, input bit sw);
    string tag;
    loadEn = ld; loadData = d; loadScale = s; captureEn = cap; swapEn = sw;
    @(posedge clk);
    modelEdge(ld, {d, s}, cap, sw);
    @(negedge clk);
    if (curTag != "")    tag = curTag;
    else if (cap && sw)  tag = "R9";
    else if (sw)         tag = "R7";
    else if (cap)        tag = "R6";
    else                 tag = "R8";
    checkPins(tag, modelPins());
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [EW-1:0] expv;
    int r;
    r = $urandom(32'h5EED_0042);
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state on the pins
    checkPins("R1", '0);
    rstN = 1'b1;
    @(negedge clk);
    checkPins("R1", '0);
    // R1: ring is zero: capture+swap of the tail shows zero
    curTag = "R1";
    step(0, '0, '0, 1, 1);
    curTag = "";

    // R2/R5: load sixteen distinct voices with paired scale codes
    for (int v = 0; v < NV; v++)
      step(1, DW'(12'hA00 + v * 12'h011), SW'(v), 0, 0);
    // after 16 loads, voice 0 is at the tail; one more edge includes it
    curTag = "R2";
    step(0, '0, '0, 1, 1);
    checkPins("R5", {12'hA00, 4'd0});
    curTag = "";
    // R6: capture without swap leaves pins unchanged
    step(0, '0, '0, 1, 0);
    checkPins("R6", {12'hA00, 4'd0});
    // swap now shows voice 1 captured above
    step(0, '0, '0, 0, 1);
    checkPins("R7", {12'hA11, 4'd1});

    // R3: voice 0 comes back after 16 further clocks (15 steps since its capture + swaps)
    repeat (13) step(0, '0, '0, 0, 0);
    curTag = "R3";
    step(0, '0, '0, 1, 1);
    checkPins("R3", {12'hA00, 4'd0});
    curTag = "";

    // R4: overwrite voice 1 as it re-enters the head, then see the new value
    step(1, 12'h5C3, 4'hE, 0, 0);
    repeat (15) step(0, '0, '0, 0, 0);
    curTag = "R4";
    step(0, '0, '0, 1, 1);
    checkPins("R4", {12'h5C3, 4'hE});
    curTag = "";

    // Evenly spaced presentation: capture+swap every 17 clocks walks the voices
    for (int k = 0; k < 20; k++) begin
      repeat (16) step(0, '0, '0, 0, 0);
      step(0, '0, '0, 1, 1);
    end

    // Constrained random traffic
    for (int n = 0; n < 6000; n++) begin
      bit ld, cap, sw;
      ld  = ($urandom % 100) < 20;
      cap = ($urandom % 100) < 30;
      sw  = ($urandom % 100) < 25;
      step(ld, DW'($urandom), SW'($urandom), cap, sw);
    end

    // Reset mid-run clears everything again (R1)
    rstN = 1'b0;
    modelReset();
    @(negedge clk);
    checkPins("R1", '0);
    rstN = 1'b1;
    curTag = "R1";
    step(0, '0, '0, 1, 1);
    curTag = "";
    expv = modelPins();
    checkPins("R1", expv);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule